// File: doc/BRIEF.md
# Parallel Backward-Limiter Merge Tree

This block evaluates, in a fixed number of clock cycles, what a serial chain of backward-recursion limiters would produce across a sliding window of W samples in a two-state soft-output detector. Each window position supplies one interval, a lower and an upper bound. A limiter clamps its input into that interval. In the serial form, the interval of the sample farthest in the future is applied first to the starting backward metric. Then each nearer sample is applied in turn, ending with sample 0.

A chain of clamps always acts like one clamp with a single combined interval. The block builds that interval with a binary tree of merge units. Each unit takes a pair of neighbouring intervals and folds them into one. It does this by clamping both bounds of the earlier-applied (inner) interval into the later-applied (outer) one. The leaf count is padded to the next power of two, and the unused leaves carry the full-range identity interval.

A final registered limiter applies the root interval to the starting metric. The root interval is also brought out, so a caller can see the combined clamp. A parameter chooses between a register after every tree level and a fully combinational tree followed only by the output register. Forward recursion and log-likelihood formation are outside this block.

Top module: `ivt_tree`

## Requirements
- R1: When the output is valid, `out_metric` equals the serial result: start from `init_metric`, clamp it into the interval of sample W-1, then sample W-2, and so on down to sample 0. Sample k occupies bits [k*MW +: MW] of `lo_flat` and of `hi_flat`, and every value is two's complement.
- R2: `out_lo` equals that same serial chain applied to the most negative metric value, and `out_hi` equals it applied to the most positive value.
- R3: If every input interval satisfies lo <= hi, every merged interval in the tree, and the output interval, also satisfy lo <= hi.
- R4: The result for inputs presented in one cycle appears ceil(log2(W))+1 cycles later when PIPELINE=1, and 1 cycle later when PIPELINE=0. `out_valid` follows `in_valid` with the same delay, and a new window may be presented every cycle.
- R5: A synchronous active-high reset clears `out_valid`, `out_metric`, `out_lo` and `out_hi` to zero.
- R6: When every sample carries the full-range interval, `out_metric` equals `init_metric`.
- R7: The output always lies inside the interval of sample 0. When sample 0 is a single point v, `out_metric` is v whatever the other samples and the starting metric are.
- R8: For a window length that is not a power of two, the padded leaves leave the result unchanged, so R1 holds exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Window inputs are valid this cycle |
| lo_flat | input | W*MW | Lower bound per sample, sample k at [k*MW +: MW] |
| hi_flat | input | W*MW | Upper bound per sample, same layout |
| init_metric | input | MW | Starting backward difference metric |
| out_valid | output | 1 | Result valid |
| out_metric | output | MW | Converged backward difference metric |
| out_lo | output | MW | Lower bound of the combined interval |
| out_hi | output | MW | Upper bound of the combined interval |

## Verification
The bench builds two instances from the same stimulus, both with 6-bit metrics. The first uses W=9 with a register after every level, which gives seven padded leaves and a five-cycle pipeline fed back to back. The second uses W=5 with a combinational tree, which gives three padded leaves and single-cycle latency. Between them they cover the delay of both variants and padding at two different depths. They also cover the collapse of disjoint intervals to a point, and full-scale bounds at the two-state metric's extremes.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    parameter int MW = 6;

    typedef logic signed [MW-1:0] metric_t;

    typedef struct packed {
        metric_t lo;
        metric_t hi;
    } span_t;

    localparam metric_t M_MIN = {1'b1, {(MW-1){1'b0}}};
    localparam metric_t M_MAX = {1'b0, {(MW-1){1'b1}}};

    function automatic span_t full_span();
        span_t s;
        s.lo = M_MIN;
        s.hi = M_MAX;
        return s;
    endfunction

    function automatic metric_t clamp(metric_t x, span_t s);
        if (x < s.lo)      return s.lo;
        else if (x > s.hi) return s.hi;
        else               return x;
    endfunction

    function automatic logic is_ordered(span_t s);
        return s.lo <= s.hi;
    endfunction

endpackage

// File: rtl/ivt_merge.sv
module ivt_merge
    import ivt_pkg::*;
(
    input  span_t outer,
    input  span_t inner,
    output span_t merged
);

    // inner is applied first, outer second: fold inner's bounds into outer
    always_comb begin
        merged.lo = clamp(inner.lo, outer);
        merged.hi = clamp(inner.hi, outer);
    end

endmodule

// File: rtl/ivt_level.sv
module ivt_level
    import ivt_pkg::*;
#(
    parameter int NODES = 1,
    parameter bit REG   = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  metric_t                in_init,
    input  span_t [2*NODES-1:0]    in_sp,
    output logic                   out_valid,
    output metric_t                out_init,
    output span_t [NODES-1:0]      out_sp
);

    span_t [NODES-1:0] merged;

    for (genvar j = 0; j < NODES; j++) begin : g_node
        ivt_merge u_merge (
            .outer (in_sp[2*j]),
            .inner (in_sp[2*j+1]),
            .merged(merged[j])
        );
    end

    if (REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                out_valid <= 1'b0;
                out_init  <= '0;
                out_sp    <= '0;
            end else begin
                out_valid <= in_valid;
                out_init  <= in_init;
                out_sp    <= merged;
            end
        end

        a_r4_level_delay: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid)
            else $error("level valid did not advance one cycle");
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_init  = in_init;
        assign out_sp    = merged;
    end

    logic in_ok, mg_ok, mg_inside;
    always_comb begin
        in_ok     = 1'b1;
        mg_ok     = 1'b1;
        mg_inside = 1'b1;
        for (int i = 0; i < 2*NODES; i++) begin
            if (!is_ordered(in_sp[i])) in_ok = 1'b0;
        end
        for (int j = 0; j < NODES; j++) begin
            if (!is_ordered(merged[j])) mg_ok = 1'b0;
            if (merged[j].lo < in_sp[2*j].lo || merged[j].hi > in_sp[2*j].hi)
                mg_inside = 1'b0;
        end
    end

    // R3: ordered intervals stay ordered through a merge
    a_r3_merge_ordered: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ok) |-> mg_ok)
        else $error("merged interval inverted");

    // R7: a merged interval never leaves its outer (later-applied) interval
    a_r7_merge_inside: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ok) |-> mg_inside)
        else $error("merged interval escapes outer interval");

endmodule

// File: rtl/ivt_limit.sv
module ivt_limit
    import ivt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  metric_t in_init,
    input  span_t   root,
    output logic    out_valid,
    output metric_t out_metric,
    output metric_t out_lo,
    output metric_t out_hi
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_metric <= '0;
            out_lo     <= '0;
            out_hi     <= '0;
        end else begin
            out_valid  <= in_valid;
            out_metric <= clamp(in_init, root);
            out_lo     <= root.lo;
            out_hi     <= root.hi;
        end
    end

    // R1/R7: the result sits inside the combined interval it came from
    a_r1_metric_in_span: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_lo <= out_hi) |-> (out_metric >= out_lo && out_metric <= out_hi))
        else $error("metric outside combined interval");

    // R5: reset clears the output stage on the next edge
    a_r5_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_metric == '0 && out_lo == '0 && out_hi == '0))
        else $error("reset did not clear outputs");

    // R4: the output stage adds exactly one cycle
    a_r4_out_delay: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid)
        else $error("output valid did not follow");

endmodule

// File: rtl/ivt_tree.sv
module ivt_tree
    import ivt_pkg::*;
#(
    parameter int W        = 9,
    parameter bit PIPELINE = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [W*ivt_pkg::MW-1:0]    lo_flat,
    input  logic [W*ivt_pkg::MW-1:0]    hi_flat,
    input  logic signed [ivt_pkg::MW-1:0] init_metric,
    output logic                        out_valid,
    output logic signed [ivt_pkg::MW-1:0] out_metric,
    output logic signed [ivt_pkg::MW-1:0] out_lo,
    output logic signed [ivt_pkg::MW-1:0] out_hi
);

    localparam int LEVELS = (W > 1) ? $clog2(W) : 0;
    localparam int LEAVES = 1 << LEVELS;

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lv
        span_t [(LEAVES >> l)-1:0] sp;
        logic                      v;
        metric_t                   init;

        if (l == 0) begin : g_leaf
            assign v    = in_valid;
            assign init = init_metric;
            for (genvar k = 0; k < LEAVES; k++) begin : g_k
                if (k < W) begin : g_real
                    assign sp[k].lo = metric_t'(lo_flat[k*MW +: MW]);
                    assign sp[k].hi = metric_t'(hi_flat[k*MW +: MW]);
                end else begin : g_pad
                    assign sp[k] = full_span();
                end
            end
        end else begin : g_merge
            ivt_level #(
                .NODES(LEAVES >> l),
                .REG  (PIPELINE)
            ) u_level (
                .clk      (clk),
                .rst      (rst),
                .in_valid (g_lv[l-1].v),
                .in_init  (g_lv[l-1].init),
                .in_sp    (g_lv[l-1].sp),
                .out_valid(v),
                .out_init (init),
                .out_sp   (sp)
            );
        end
    end

    ivt_limit u_limit (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (g_lv[LEVELS].v),
        .in_init   (g_lv[LEVELS].init),
        .root      (g_lv[LEVELS].sp[0]),
        .out_valid (out_valid),
        .out_metric(out_metric),
        .out_lo    (out_lo),
        .out_hi    (out_hi)
    );

    // R3: ordered output interval whenever it is valid after ordered inputs
    a_r3_out_ordered: assert property (@(posedge clk) disable iff (rst)
        (g_lv[LEVELS].v && is_ordered(g_lv[LEVELS].sp[0])) |=> (out_lo <= out_hi))
        else $error("output interval inverted");

endmodule

// File: tb/ivt_tree_bench.sv
module ivt_tree_bench;
    import ivt_pkg::*;

    localparam int WA = 9;
    localparam int WB = 5;
    localparam int LAT_A = $clog2(WA) + 1;
    localparam int LAT_B = 1;
    localparam int NCYC = 700;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic                 in_valid = 1'b0;
    logic [WA*MW-1:0]     lo_flat = '0, hi_flat = '0;
    logic signed [MW-1:0] init_metric = '0;
    logic                 va, vb;
    logic signed [MW-1:0] ma, la, ha, mb, lb, hb;

    ivt_tree #(.W(WA), .PIPELINE(1'b1)) u_ivt_tree (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .lo_flat(lo_flat), .hi_flat(hi_flat), .init_metric(init_metric),
        .out_valid(va), .out_metric(ma), .out_lo(la), .out_hi(ha));

    ivt_tree #(.W(WB), .PIPELINE(1'b0)) u_ivt_tree_flat (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .lo_flat(lo_flat[WB*MW-1:0]), .hi_flat(hi_flat[WB*MW-1:0]),
        .init_metric(init_metric),
        .out_valid(vb), .out_metric(mb), .out_lo(lb), .out_hi(hb));

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int los[WA], his[WA];

    int ea_m[16], ea_l[16], ea_h[16], eb_m[16], eb_l[16], eb_h[16];
    bit e_v[16];
    int e_mode[16], e_s0[16];

    function automatic int clampi(int x, int l, int h);
        if (x < l) return l;
        if (x > h) return h;
        return x;
    endfunction

    function automatic int chain(int x, int cnt);
        int m = x;
        for (int k = cnt - 1; k >= 0; k--) m = clampi(m, los[k], his[k]);
        return m;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int rnd_val();
        return int'($urandom % (1 << MW)) - (1 << (MW-1));
    endfunction

    task automatic make_vector(int mode);
        int a, b;
        for (int k = 0; k < WA; k++) begin
            a = rnd_val(); b = rnd_val();
            case (mode)
                1: begin a = -(1 << (MW-1)); b = (1 << (MW-1)) - 1; end
                3: begin b = clampi(a + int'($urandom % 4), -(1 << (MW-1)), (1 << (MW-1)) - 1); end
                default: ;
            endcase
            if (a > b) begin los[k] = b; his[k] = a; end
            else       begin los[k] = a; his[k] = b; end
        end
        if (mode == 2) begin
            los[0] = rnd_val(); his[0] = los[0];
            los[1] = -(1 << (MW-1)); his[1] = -(1 << (MW-1));
        end
        for (int k = 0; k < WA; k++) begin
            lo_flat[k*MW +: MW] = MW'(los[k]);
            hi_flat[k*MW +: MW] = MW'(his[k]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int s = 0; s < 16; s++) e_v[s] = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R5: reset state
        chk("R5 valid A", int'(va), 0);
        chk("R5 metric A", int'(ma), 0);
        chk("R5 lo A", int'(la), 0);
        chk("R5 hi B", int'(hb), 0);
        chk("R5 valid B", int'(vb), 0);

        for (int n = 0; n < NCYC; n++) begin
            int sa, sb, mode, iv;
            if (n >= LAT_A) begin
                sa = (n - LAT_A) % 16;
                chk("R4 valid A", int'(va), int'(e_v[sa]));
                if (e_v[sa]) begin
                    chk("R1 R8 metric A", int'(ma), ea_m[sa]);
                    chk("R2 lo A", int'(la), ea_l[sa]);
                    chk("R2 hi A", int'(ha), ea_h[sa]);
                    chk("R3 order A", int'(la <= ha), 1);
                    if (e_mode[sa] == 2) chk("R7 point A", int'(ma), e_s0[sa]);
                end
            end else begin
                chk("R4 idle A", int'(va), 0);
            end
            if (n >= LAT_B) begin
                sb = (n - LAT_B) % 16;
                chk("R4 valid B", int'(vb), int'(e_v[sb]));
                if (e_v[sb]) begin
                    chk("R1 metric B", int'(mb), eb_m[sb]);
                    chk("R2 lo B", int'(lb), eb_l[sb]);
                    chk("R2 hi B", int'(hb), eb_h[sb]);
                    if (e_mode[sb] == 1) chk("R6 identity B", int'(mb), eb_m[sb]);
                    if (e_mode[sb] == 2) chk("R7 point B", int'(mb), e_s0[sb]);
                end
            end

            if (n < 40)       mode = n % 4;
            else if (n < 60)  mode = 1;
            else              mode = int'($urandom % 5) == 0 ? 3 : 0;
            if (n % 37 == 5) mode = 2;
            iv = (n % 11 == 7) ? 0 : 1;
            make_vector(mode);
            case (n % 13)
                0: init_metric = MW'(-(1 << (MW-1)));
                1: init_metric = MW'((1 << (MW-1)) - 1);
                default: init_metric = MW'(rnd_val());
            endcase
            in_valid = iv[0];
            sa = n % 16;
            e_v[sa]    = iv[0];
            e_mode[sa] = mode;
            e_s0[sa]   = los[0];
            ea_m[sa] = chain(int'(init_metric), WA);
            ea_l[sa] = chain(-(1 << (MW-1)), WA);
            ea_h[sa] = chain((1 << (MW-1)) - 1, WA);
            eb_m[sa] = chain(int'(init_metric), WB);
            eb_l[sa] = chain(-(1 << (MW-1)), WB);
            eb_h[sa] = chain((1 << (MW-1)) - 1, WB);
            if (mode == 1) begin
                // R6: full-range intervals pass the starting metric through
                chk("R6 model", eb_m[sa], int'(init_metric));
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (LAT_A + 1) @(negedge clk);
        chk("R4 drain A", int'(va), 0);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R5 rerst metric A", int'(ma), 0);
        chk("R5 rerst metric B", int'(mb), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule